// File: doc/BRIEF.md
# HDLC Frame Serializer with Line-Fill Modes

This block turns queued bytes into a bit-serial HDLC line. It reads entries from an external byte queue. Each entry carries a data byte and two tag bits: last-byte-of-packet and kill-packet. The block wraps each packet in 7E flags and inserts zero bits into the data. When an entry is tagged for kill, it sends a run of eight ones in place of that byte. Between packets it fills the line with one of four selectable patterns. One of these is a transparent mode in which queued bytes go out raw, with no framing.

Every symbol on the line is eight bits long: a data byte, a flag, an abort, or a fill byte. A per-bit clock enable advances the line by one bit. The serial bit comes with an output-enable, so an external pad can tri-state the line. The transmit enable is honoured only between packets. The exception is transparent mode, where clearing it cuts the line at once.

Top module: `hdlc_tx_framer`

## Requirements
- R1: During and after reset, before any enabled bit step, ser_oe is 0, ser_out is 1, underrun is 0 and fifo_pop is 0. Whenever ser_oe is 0, ser_out is 1.
- R2: The line-fill patterns apply when the block is idle, tx_enable is 1 and the queue is empty. fill_sel 00 sends FF, 01 sends 7E and 11 sends 7F. Each byte is sent least-significant bit first and is never stuffed. A change of fill_sel takes effect at the next byte boundary.
- R3: A packet starts when the block is idle with tx_enable at 1, fill_sel not 10, and the queue non-empty. The block sends the flag 7E, then the queued bytes LSB first. fifo_pop is high in the cycle in which the first bit of each taken byte is decided.
- R4: Inside packet data, a 0 is inserted after every five consecutive ones. The count carries across byte boundaries and restarts at the opening flag. Flags, aborts and fill bytes are never stuffed.
- R5: After a byte tagged with fifo_eop=1 (and fifo_abort=0), a closing 7E flag follows. A next packet, if queued, then starts with its own opening flag.
- R6: A byte tagged with fifo_abort=1 is popped but never sent. Eight ones go out in its place and the packet ends. The kill tag takes priority over the last-byte tag.
- R7: The queue may be empty at a byte boundary inside a packet that has not been closed. In that case the block sends eight ones, raises underrun for exactly one clock, and ends the packet.
- R8: Clearing tx_enable while a packet is in progress has no effect until the closing flag or the abort has been sent. At the next byte boundary outside a packet with tx_enable at 0, ser_oe goes to 0.
- R9: With fill_sel 10 and tx_enable at 1, queued bytes are sent LSB first with no flags and no stuffing. Both tag bits are ignored. When the queue is empty, FF is sent.
- R10: While a transparent byte is on the line, clearing tx_enable drops ser_oe at the next enabled bit step. The remaining bits of that byte are discarded.
- R11: In a cycle with bit_en at 0, ser_out and ser_oe hold their values and fifo_pop stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Advance the line by one bit in this cycle |
| tx_enable | input | 1 | Transmit enable (packet-granular, immediate in transparent mode) |
| fill_sel | input | 2 | 00 ones, 01 flags, 10 transparent, 11 7F go-ahead |
| fifo_valid | input | 1 | Queue head holds an entry |
| fifo_data | input | 8 | Data byte at queue head |
| fifo_eop | input | 1 | Head entry is the last byte of its packet |
| fifo_abort | input | 1 | Head entry is to be replaced by an abort |
| fifo_pop | output | 1 | Head entry is taken in this cycle |
| ser_out | output | 1 | Serial line bit |
| ser_oe | output | 1 | Drive enable for the serial line |
| underrun | output | 1 | One-clock pulse when a packet is starved |

## Verification
Two situations can share one bit step. The first is a stuffed zero that is still owed when a data byte's bits run out: the boundary then waits one step before the closing flag or the next byte starts. The bench provokes this with a last byte whose top five bits are ones, and with an all-ones byte followed by more ones. The second is a transparent cut that lands exactly on a byte boundary, where the cut must beat a fresh raw load. The bench drops tx_enable at varying offsets under irregular bit_en patterns. A queue-based model of the line bit stream judges every cycle, along with the expected pop and underrun.

// File: rtl/hdlc_tx_pkg.sv
`timescale 1ns/1ps
package hdlc_tx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FLAG_PAT = 8'h7E;
  localparam logic [BYTE_W-1:0] ONES_PAT = 8'hFF;
  localparam logic [1:0] FILL_TRANSP = 2'b10;

  typedef enum logic [2:0] {
    K_OFF, K_FILL, K_OPEN, K_DATA, K_CLOSE, K_ABORT, K_RAW
  } sym_kind_e;

  // byte sent between packets for a framed fill selection
  function automatic logic [BYTE_W-1:0] fill_byte(input logic [1:0] sel);
    case (sel)
      2'b01:   return FLAG_PAT;
      2'b11:   return 8'h7F;
      default: return ONES_PAT;
    endcase
  endfunction
endpackage

// File: rtl/hdlc_tx_shifter.sv
`timescale 1ns/1ps
module hdlc_tx_shifter
  import hdlc_tx_pkg::*;
#(
  parameter int STUFF_RUN = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_en,
  input  logic                 load,
  input  sym_kind_e            load_kind,
  input  logic [BYTE_W-1:0]    load_pat,
  output sym_kind_e            cur_kind,
  output logic                 sym_done,
  output logic                 stuff_now,
  output logic                 ser_out,
  output logic                 ser_oe
);
  localparam int OW = $clog2(STUFF_RUN + 1);
  localparam int LW = $clog2(BYTE_W);
  localparam logic [OW-1:0] RUN_MAX = OW'(STUFF_RUN);
  localparam logic [LW-1:0] LAST_IDX = LW'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh_q;
  logic [LW-1:0]     left_q;
  logic [OW-1:0]     ones_q;
  logic [OW-1:0]     ones_on_load;

  // a stuffed zero is owed once a full run of data ones has gone out
  assign stuff_now = (cur_kind == K_DATA) && (ones_q == RUN_MAX);
  assign sym_done  = (left_q == '0) && !stuff_now;

  always_comb begin
    if (load_kind == K_DATA && load_pat[0]) ones_on_load = ones_q + 1'b1;
    else                                    ones_on_load = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_kind <= K_OFF;
      sh_q     <= '0;
      left_q   <= '0;
      ones_q   <= '0;
      ser_out  <= 1'b1;
      ser_oe   <= 1'b0;
    end else if (bit_en) begin
      if (load) begin
        cur_kind <= load_kind;
        sh_q     <= load_pat >> 1;
        ser_out  <= load_pat[0];
        ser_oe   <= (load_kind != K_OFF);
        left_q   <= (load_kind == K_OFF) ? '0 : LAST_IDX;
        ones_q   <= ones_on_load;
      end else if (stuff_now) begin
        ser_out <= 1'b0;
        ones_q  <= '0;
      end else begin
        ser_out <= sh_q[0];
        sh_q    <= sh_q >> 1;
        left_q  <= left_q - 1'b1;
        ones_q  <= (cur_kind == K_DATA && sh_q[0]) ? ones_q + 1'b1 : '0;
      end
    end
  end
endmodule

// File: rtl/hdlc_tx_ctrl.sv
`timescale 1ns/1ps
module hdlc_tx_ctrl
  import hdlc_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              sym_done,
  input  sym_kind_e         cur_kind,
  input  logic              tx_enable,
  input  logic [1:0]        fill_sel,
  input  logic              fifo_valid,
  input  logic [BYTE_W-1:0] fifo_data,
  input  logic              fifo_eop,
  input  logic              fifo_abort,
  output logic              load,
  output sym_kind_e         load_kind,
  output logic [BYTE_W-1:0] load_pat,
  output logic              fifo_pop,
  output logic              underrun,
  output logic              in_packet,
  output logic              raw_cut
);
  logic pkt_q, close_q, pkt_d, close_d, take, starve;

  assign raw_cut   = (cur_kind == K_RAW) && !tx_enable;
  assign load      = bit_en && (sym_done || raw_cut);
  assign fifo_pop  = load && take;
  assign in_packet = pkt_q;

  always_comb begin
    load_kind = K_OFF;
    load_pat  = ONES_PAT;
    take      = 1'b0;
    starve    = 1'b0;
    pkt_d     = pkt_q;
    close_d   = close_q;
    if (raw_cut) begin
      load_kind = K_OFF;
    end else if (pkt_q) begin
      if (close_q) begin
        load_kind = K_CLOSE;
        load_pat  = FLAG_PAT;
        pkt_d     = 1'b0;
        close_d   = 1'b0;
      end else if (fifo_valid) begin
        take = 1'b1;
        if (fifo_abort) begin
          load_kind = K_ABORT;
          pkt_d     = 1'b0;
        end else begin
          load_kind = K_DATA;
          load_pat  = fifo_data;
          close_d   = fifo_eop;
        end
      end else begin
        load_kind = K_ABORT;
        starve    = 1'b1;
        pkt_d     = 1'b0;
      end
    end else if (fill_sel == FILL_TRANSP) begin
      if (tx_enable) begin
        load_kind = K_RAW;
        if (fifo_valid) begin
          take     = 1'b1;
          load_pat = fifo_data;
        end
      end
    end else if (tx_enable) begin
      if (fifo_valid) begin
        load_kind = K_OPEN;
        load_pat  = FLAG_PAT;
        pkt_d     = 1'b1;
        close_d   = 1'b0;
      end else begin
        load_kind = K_FILL;
        load_pat  = fill_byte(fill_sel);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_q    <= 1'b0;
      close_q  <= 1'b0;
      underrun <= 1'b0;
    end else begin
      underrun <= load && starve;
      if (load) begin
        pkt_q   <= pkt_d;
        close_q <= close_d;
      end
    end
  end
endmodule

// File: rtl/hdlc_tx_framer.sv
`timescale 1ns/1ps
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int STUFF_RUN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              tx_enable,
  input  logic [1:0]        fill_sel,
  input  logic              fifo_valid,
  input  logic [BYTE_W-1:0] fifo_data,
  input  logic              fifo_eop,
  input  logic              fifo_abort,
  output logic              fifo_pop,
  output logic              ser_out,
  output logic              ser_oe,
  output logic              underrun
);
  logic              load;
  sym_kind_e         load_kind;
  logic [BYTE_W-1:0] load_pat;
  sym_kind_e         cur_kind;
  logic              sym_done;
  logic              stuff_now;
  logic              in_packet;
  logic              raw_cut;

  hdlc_tx_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .sym_done   (sym_done),
    .cur_kind   (cur_kind),
    .tx_enable  (tx_enable),
    .fill_sel   (fill_sel),
    .fifo_valid (fifo_valid),
    .fifo_data  (fifo_data),
    .fifo_eop   (fifo_eop),
    .fifo_abort (fifo_abort),
    .load       (load),
    .load_kind  (load_kind),
    .load_pat   (load_pat),
    .fifo_pop   (fifo_pop),
    .underrun   (underrun),
    .in_packet  (in_packet),
    .raw_cut    (raw_cut)
  );

  hdlc_tx_shifter #(.STUFF_RUN(STUFF_RUN)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .load      (load),
    .load_kind (load_kind),
    .load_pat  (load_pat),
    .cur_kind  (cur_kind),
    .sym_done  (sym_done),
    .stuff_now (stuff_now),
    .ser_out   (ser_out),
    .ser_oe    (ser_oe)
  );
endmodule

// File: rtl/hdlc_tx_framer_chk.sv
`timescale 1ns/1ps
module hdlc_tx_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic fifo_valid,
  input logic fifo_pop,
  input logic ser_out,
  input logic ser_oe,
  input logic underrun,
  input logic stuff_now,
  input logic in_packet,
  input logic raw_cut
);
  AST_RELEASED_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_oe |-> ser_out); // R1
  AST_POP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (fifo_valid && bit_en)); // R11
  AST_UNDERRUN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun); // R7
  AST_STUFF_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && stuff_now) |=> (!ser_out && ser_oe)); // R4
  AST_PACKET_HOLDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && in_packet) |=> ser_oe); // R8
  AST_RAW_CUT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && raw_cut) |=> !ser_oe); // R10
endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk u_chk (.*);

// File: tb/test_hdlc_tx_framer.sv
`timescale 1ns/1ps
module test_hdlc_tx_framer;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       tx_enable = 1'b0;
  logic [1:0] fill_sel = 2'b00;
  logic       fifo_valid = 1'b0;
  logic [7:0] fifo_data = 8'h00;
  logic       fifo_eop = 1'b0;
  logic       fifo_abort = 1'b0;
  logic       fifo_pop, ser_out, ser_oe, underrun;

  hdlc_tx_framer i_hdlc_tx_framer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_enable(tx_enable),
    .fill_sel(fill_sel), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
    .fifo_eop(fifo_eop), .fifo_abort(fifo_abort), .fifo_pop(fifo_pop),
    .ser_out(ser_out), .ser_oe(ser_oe), .underrun(underrun)
  );

  typedef struct packed { logic ab; logic eop; logic [7:0] d; } ent_t;
  ent_t fq[$];
  bit   bq[$];
  bit   oq[$];
  bit   m_out = 1'b1, m_oe = 1'b0, m_pkt = 1'b0, m_close = 1'b0, m_raw = 1'b0;
  int   m_ones = 0;
  int   errs = 0, checks = 0;
  string cur = "R1";

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic eop, input logic ab);
    fq.push_back('{ab: ab, eop: eop, d: d});
  endtask

  task automatic put_byte(input logic [7:0] b, input bit stuffed);
    for (int i = 0; i < 8; i++) begin
      bq.push_back(b[i]); oq.push_back(1'b1);
      if (stuffed) begin
        m_ones = b[i] ? m_ones + 1 : 0;
        if (m_ones == 5) begin bq.push_back(1'b0); oq.push_back(1'b1); m_ones = 0; end
      end
    end
  endtask

  task automatic put_off();
    bq.push_back(1'b1); oq.push_back(1'b0); m_raw = 1'b0;
  endtask

  task automatic generate_next(inout logic ep, inout logic eu);
    ent_t e;
    if (m_pkt) begin
      m_raw = 1'b0;
      if (m_close) begin put_byte(8'h7E, 0); m_pkt = 0; m_close = 0; end
      else if (fq.size() > 0) begin
        e = fq.pop_front(); ep = 1'b1;
        if (e.ab) begin put_byte(8'hFF, 0); m_pkt = 0; end
        else begin put_byte(e.d, 1); m_close = e.eop; end
      end else begin put_byte(8'hFF, 0); m_pkt = 0; eu = 1'b1; end
    end else if (fill_sel == 2'b10) begin
      if (!tx_enable) put_off();
      else if (fq.size() > 0) begin e = fq.pop_front(); ep = 1'b1; put_byte(e.d, 0); m_raw = 1'b1; end
      else begin put_byte(8'hFF, 0); m_raw = 1'b1; end
    end else begin
      m_raw = 1'b0;
      if (!tx_enable) put_off();
      else if (fq.size() > 0) begin put_byte(8'h7E, 0); m_pkt = 1; m_close = 0; m_ones = 0; end
      else if (fill_sel == 2'b01) put_byte(8'h7E, 0);
      else if (fill_sel == 2'b11) put_byte(8'h7F, 0);
      else put_byte(8'hFF, 0);
    end
  endtask

  task automatic tick(input logic be);
    logic ep, eu;
    ep = 1'b0; eu = 1'b0;
    bit_en = be;
    fifo_valid = (fq.size() > 0);
    {fifo_abort, fifo_eop, fifo_data} = fifo_valid ? fq[0] : '0;
    if (be) begin
      if (m_raw && !tx_enable) begin
        bq.delete(); oq.delete(); m_raw = 1'b0; m_out = 1'b1; m_oe = 1'b0;
      end else begin
        if (bq.size() == 0) generate_next(ep, eu);
        m_out = bq.pop_front(); m_oe = oq.pop_front();
      end
    end
    #1;
    chk(be ? cur : "R11", "fifo_pop", fifo_pop, ep);
    @(posedge clk);
    @(negedge clk);
    chk(be ? cur : "R11", "ser_out", ser_out, m_out);
    chk(be ? cur : "R11", "ser_oe", ser_oe, m_oe);
    chk(cur, "underrun", underrun, eu);
  endtask

  task automatic run(input int n, input int gap);
    for (int i = 0; i < n; i++) tick((gap == 0) || ((i % gap) != (gap - 1)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "ser_oe", ser_oe, 1'b0);
    chk("R1", "ser_out", ser_out, 1'b1);
    chk("R1", "underrun", underrun, 1'b0);
    chk("R1", "fifo_pop", fifo_pop, 1'b0);
    rst_n = 1'b1;
    cur = "R1"; run(4, 0);
    cur = "R8"; tx_enable = 0; run(10, 0);
    cur = "R2"; tx_enable = 1; fill_sel = 2'b00; run(20, 0);
    fill_sel = 2'b01; run(21, 3);
    fill_sel = 2'b11; run(25, 0);
    cur = "R11"; run(30, 2);
    push(8'h3C, 0, 0);
    for (int i = 0; i < 5; i++) tick(1'b0);
    run(40, 4);
    cur = "R3"; fill_sel = 2'b01;
    push(8'hA5, 0, 0); push(8'h3C, 1, 0); run(60, 0);
    cur = "R4"; push(8'hFF, 0, 0); push(8'h1F, 0, 0); push(8'hF8, 1, 0); run(90, 3);
    cur = "R5"; push(8'h11, 1, 0); push(8'h22, 1, 0); run(60, 0);
    cur = "R6"; push(8'h55, 0, 0); push(8'hAA, 1, 1); push(8'h77, 1, 0); run(80, 0);
    cur = "R7"; push(8'h12, 0, 0); push(8'h34, 0, 0); run(60, 0);
    cur = "R8"; fill_sel = 2'b00;
    for (int i = 0; i < 4; i++) push(8'h0F + 8'(i), 0, 0);
    push(8'hE7, 1, 0); run(10, 0); tx_enable = 0; run(80, 5);
    cur = "R9"; fill_sel = 2'b10; tx_enable = 1;
    push(8'h81, 0, 0); push(8'h7E, 1, 0); push(8'hC3, 0, 1); run(40, 0);
    cur = "R10"; push(8'hF0, 0, 0); run(5, 0); tx_enable = 0; run(10, 0);
    tx_enable = 1; run(16, 0); tx_enable = 0; run(6, 3);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule